// File: doc/BRIEF.md
# TDM Serial Audio Frame Transmitter

This block turns parallel audio words into a single serial data line organised as time-division-multiplexed frames. Each system clock cycle carries one bit. A frame is a programmable number of slots, and each slot a programmable number of bits. The block drives a frame sync beside the data. The sync can be one bit or one slot long, can lead the first data bit by one bit, and can be active high or active low. With these settings the block produces I2S, left- and right-justified and both DSP-style timings.

Words arrive on a valid/ready handshake and are taken only for slots that carry data. A slot carries data when it is enabled in the slot mask, and, in normal (single-channel) mode, only when it is slot 0. When the slot is wider than the word, the word is left- or right-aligned and the spare bits are zero. Three status outputs accompany the data: an underrun pulse, a last-slot pulse and an even-slot level.

Configuration is captured by a write strobe and only while the transmitter is idle. Transmission starts when `run` is high and stops at the next frame boundary at which `run` is low.

Top module: `tdm_fmt_tx`

## Requirements
- R1: After reset, `sdOut`, `fsOut`, `inReady`, `underrun`, `lastSlot` and `evenSlot` are 0. The configuration after reset is 2 slots of 32 bits, 32-bit words, every slot enabled, a one-slot-long active-high sync with no lead, left alignment and network mode.
- R2: Each slot is sent most significant bit first. With left alignment (`cfgRightAlign`=0), the low `cfgWordWidth` bits of `inWord` fill the top of the slot and the remaining low bits are zero.
- R3: With `cfgRightAlign`=1, the word fills the low `cfgWordWidth` bits of the slot and the leading bits are zero.
- R4: A slot whose bit in `cfgSlotMask` (bit n for slot n) is 0 sends zeros, keeps `inReady` low and takes no word.
- R5: With `cfgNetwork`=0, only slot 0 can carry data; all other slots send zeros and take no word.
- R6: With `cfgSyncWord`=0, the sync is active for the first bit of slot 0 only. With `cfgSyncWord`=1, it is active for all of slot 0.
- R7: With `cfgSyncEarly`=1, the sync window moves one bit earlier. It starts in the last bit of the previous frame. The first frame after a start is preceded by one lead cycle, in which the sync is active and the data is 0.
- R8: `fsOut` is the active sync XOR `cfgSyncLow`, so 1 selects an active-low sync. When idle, `fsOut` equals `cfgSyncLow`.
- R9: When a data-carrying slot begins and `inValid` is 0, the slot sends all zeros and `underrun` pulses during the slot's first bit.
- R10: `lastSlot` pulses during the first bit of the final slot of each frame. `evenSlot` is high while an even-numbered slot is being sent.
- R11: `run` is sampled at each frame's last bit. If it is low there, the block goes idle after that bit. While idle, `sdOut` is 0. The first bit (or the lead cycle) is sent in the cycle after `run` is first seen high.
- R12: `cfgWrite` is ignored while a transmission is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Capture the cfg* inputs (idle only) |
| cfgSlotsM1 | input | SLOT_W | Slots per frame minus one |
| cfgSlotWidth | input | CNT_W | Bits per slot |
| cfgWordWidth | input | CNT_W | Bits per word (not above slot width) |
| cfgSlotMask | input | MAX_SLOTS | Slot enables, bit n for slot n |
| cfgSyncWord | input | 1 | 1: sync lasts one slot; 0: one bit |
| cfgSyncEarly | input | 1 | Sync leads data by one bit |
| cfgSyncLow | input | 1 | Active-low sync |
| cfgRightAlign | input | 1 | Right-align the word in its slot |
| cfgNetwork | input | 1 | 1: all enabled slots; 0: slot 0 only |
| run | input | 1 | Request transmission |
| inWord | input | DATA_W | Audio word |
| inValid | input | 1 | Word available |
| inReady | output | 1 | Word taken at this edge when valid |
| sdOut | output | 1 | Serial data |
| fsOut | output | 1 | Frame sync |
| underrun | output | 1 | Slot started with no word |
| lastSlot | output | 1 | First bit of the final slot |
| evenSlot | output | 1 | Even slot being sent |

## Verification
All results are due on a fixed schedule. The data bit, sync and even-slot level for a bit position appear one cycle after the edge that enters that position. The word handshake happens on the edge that enters the slot. The underrun and last-slot pulses show during the slot's first bit. The bench samples on the falling edge: the first expected entry is compared one full cycle after the edge that sees `run` high, and each later entry one cycle after the previous one. `run` is dropped during the final expected bit so that the frame-end edge stops the block. Word counts and the idle levels are checked a few cycles after the last bit.

// File: rtl/tdm_fmt_pkg.sv
package tdm_fmt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_RUN} fmtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // enter a new slot at this edge
    logic take;    // a word is accepted for that slot
    logic shift;   // advance one bit within the slot
  } fmtStrobe_t;
endpackage

// File: rtl/tdm_fmt_ctrl.sv
module tdm_fmt_ctrl
  import tdm_fmt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_SLOTS = 16,
  localparam int CNT_W    = $clog2(DATA_W + 1),
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [SLOT_W-1:0]    cfgSlotsM1,
  input  logic [CNT_W-1:0]     cfgSlotWidth,
  input  logic [CNT_W-1:0]     cfgWordWidth,
  input  logic [MAX_SLOTS-1:0] cfgSlotMask,
  input  logic                 cfgSyncWord,
  input  logic                 cfgSyncEarly,
  input  logic                 cfgSyncLow,
  input  logic                 cfgRightAlign,
  input  logic                 cfgNetwork,
  input  logic                 run,
  input  logic                 inValid,
  output logic                 inReady,
  output fmtStrobe_t           strobe,
  output logic                 txOn,
  output logic                 leadOn,
  output logic                 fsOut,
  output logic                 underrun,
  output logic                 lastSlot,
  output logic                 evenSlot,
  output logic [CNT_W-1:0]     slotWidth,
  output logic [CNT_W-1:0]     wordWidth,
  output logic                 rightAlign,
  output logic                 syncLow,
  output logic [SLOT_W-1:0]    slotsM1
);
  localparam logic [CNT_W-1:0] FULL_W = CNT_W'(DATA_W);

  // configuration held while running
  logic [MAX_SLOTS-1:0] maskR;
  logic syncWordR, earlyR, networkR;

  fmtState_t state;
  logic [CNT_W-1:0]  bitIdx;
  logic [SLOT_W-1:0] slotIdx;

  logic [CNT_W-1:0]  slotWm1;
  logic              atSlotEnd, atFrameEnd, loadNow, nextActive;
  logic              inSlot0, fsActive;
  logic [SLOT_W-1:0] nextSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotsM1    <= SLOT_W'(1);
      slotWidth  <= FULL_W;
      wordWidth  <= FULL_W;
      maskR      <= '1;
      syncWordR  <= 1'b1;
      earlyR     <= 1'b0;
      syncLow    <= 1'b0;
      rightAlign <= 1'b0;
      networkR   <= 1'b1;
    end else if (cfgWrite && state == ST_IDLE) begin
      slotsM1    <= cfgSlotsM1;
      slotWidth  <= cfgSlotWidth;
      wordWidth  <= cfgWordWidth;
      maskR      <= cfgSlotMask;
      syncWordR  <= cfgSyncWord;
      earlyR     <= cfgSyncEarly;
      syncLow    <= cfgSyncLow;
      rightAlign <= cfgRightAlign;
      networkR   <= cfgNetwork;
    end
  end

  always_comb begin
    slotWm1    = slotWidth - CNT_W'(1);
    atSlotEnd  = (state == ST_RUN) && (bitIdx == slotWm1);
    atFrameEnd = atSlotEnd && (slotIdx == slotsM1);
    loadNow    = (state == ST_IDLE && run && !earlyR) ||
                 (state == ST_LEAD) ||
                 (atSlotEnd && !(atFrameEnd && !run));
    nextSlot   = (state != ST_RUN || atFrameEnd) ? '0 : slotIdx + SLOT_W'(1);
    nextActive = maskR[nextSlot] && (networkR || nextSlot == '0);
    inReady    = loadNow && nextActive;
    strobe.load  = loadNow;
    strobe.take  = loadNow && nextActive && inValid;
    strobe.shift = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      slotIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (run) begin
          state   <= earlyR ? ST_LEAD : ST_RUN;
          bitIdx  <= '0;
          slotIdx <= '0;
        end
        ST_LEAD: begin
          state  <= ST_RUN;
          bitIdx <= '0;
        end
        ST_RUN: begin
          if (atFrameEnd && !run) begin
            state <= ST_IDLE;
          end else if (atSlotEnd) begin
            slotIdx <= nextSlot;
            bitIdx  <= '0;
          end else begin
            bitIdx <= bitIdx + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // slot-level status pulses, shown during the first bit of the new slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrun <= 1'b0;
      lastSlot <= 1'b0;
    end else begin
      underrun <= loadNow && nextActive && !inValid;
      lastSlot <= loadNow && (nextSlot == slotsM1);
    end
  end

  always_comb begin
    txOn     = (state == ST_RUN);
    leadOn   = (state == ST_LEAD);
    evenSlot = txOn && !slotIdx[0];
    inSlot0  = txOn && (slotIdx == '0);
    unique case ({earlyR, syncWordR})
      2'b00:   fsActive = inSlot0 && (bitIdx == '0);
      2'b01:   fsActive = inSlot0;
      2'b10:   fsActive = leadOn || atFrameEnd;
      default: fsActive = leadOn || atFrameEnd || (inSlot0 && bitIdx != slotWm1);
    endcase
    fsOut = fsActive ^ syncLow;
  end
endmodule

// File: rtl/tdm_fmt_dpath.sv
module tdm_fmt_dpath
  import tdm_fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strobe,
  input  logic [DATA_W-1:0] inWord,
  input  logic [CNT_W-1:0]  wordWidth,
  input  logic [CNT_W-1:0]  slotWidth,
  input  logic              rightAlign,
  input  logic              txOn,
  output logic              sdOut
);
  localparam logic [CNT_W-1:0] FULL_W = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shifter, wordMask, placed;
  logic [CNT_W-1:0]  shAmt;

  // slot image held left-justified: bit DATA_W-1 is the bit on the line
  always_comb begin
    wordMask = ~({DATA_W{1'b1}} << wordWidth);
    shAmt    = rightAlign ? (FULL_W - slotWidth) : (FULL_W - wordWidth);
    placed   = (inWord & wordMask) << shAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             shifter <= '0;
    else if (strobe.load)  shifter <= strobe.take ? placed : '0;
    else if (strobe.shift) shifter <= shifter << 1;
  end

  assign sdOut = txOn & shifter[DATA_W-1];
endmodule

// File: rtl/tdm_fmt_tx.sv
module tdm_fmt_tx
  import tdm_fmt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_SLOTS = 16,
  localparam int CNT_W    = $clog2(DATA_W + 1),
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [SLOT_W-1:0]    cfgSlotsM1,
  input  logic [CNT_W-1:0]     cfgSlotWidth,
  input  logic [CNT_W-1:0]     cfgWordWidth,
  input  logic [MAX_SLOTS-1:0] cfgSlotMask,
  input  logic                 cfgSyncWord,
  input  logic                 cfgSyncEarly,
  input  logic                 cfgSyncLow,
  input  logic                 cfgRightAlign,
  input  logic                 cfgNetwork,
  input  logic                 run,
  input  logic [DATA_W-1:0]    inWord,
  input  logic                 inValid,
  output logic                 inReady,
  output logic                 sdOut,
  output logic                 fsOut,
  output logic                 underrun,
  output logic                 lastSlot,
  output logic                 evenSlot
);
  fmtStrobe_t        strobe;
  logic              txOn, leadOn, rightAlign, syncLow;
  logic [CNT_W-1:0]  slotWidth, wordWidth;
  logic [SLOT_W-1:0] slotsM1;

  tdm_fmt_ctrl #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSlotsM1(cfgSlotsM1),
    .cfgSlotWidth(cfgSlotWidth), .cfgWordWidth(cfgWordWidth),
    .cfgSlotMask(cfgSlotMask), .cfgSyncWord(cfgSyncWord),
    .cfgSyncEarly(cfgSyncEarly), .cfgSyncLow(cfgSyncLow),
    .cfgRightAlign(cfgRightAlign), .cfgNetwork(cfgNetwork), .run(run),
    .inValid(inValid), .inReady(inReady), .strobe(strobe), .txOn(txOn),
    .leadOn(leadOn), .fsOut(fsOut), .underrun(underrun), .lastSlot(lastSlot),
    .evenSlot(evenSlot), .slotWidth(slotWidth), .wordWidth(wordWidth),
    .rightAlign(rightAlign), .syncLow(syncLow), .slotsM1(slotsM1)
  );

  tdm_fmt_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWord(inWord),
    .wordWidth(wordWidth), .slotWidth(slotWidth), .rightAlign(rightAlign),
    .txOn(txOn), .sdOut(sdOut)
  );
endmodule

// File: rtl/tdm_fmt_chk.sv
module tdm_fmt_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              txOn,
  input logic              leadOn,
  input logic              sdOut,
  input logic              fsOut,
  input logic              syncLow,
  input logic              underrun,
  input logic              lastSlot,
  input logic              inReady,
  input logic              inValid,
  input logic [SLOT_W-1:0] slotsM1
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !txOn |-> !sdOut);

  assert_idle_sync_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!txOn && !leadOn) |-> (fsOut == syncLow));

  assert_last_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    lastSlot |=> !lastSlot);

  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(inReady && !inValid));

  assert_underrun_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !sdOut);

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (txOn && $past(txOn)) |-> $stable(slotsM1));
endmodule

bind tdm_fmt_tx tdm_fmt_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .txOn(txOn), .leadOn(leadOn), .sdOut(sdOut),
  .fsOut(fsOut), .syncLow(syncLow), .underrun(underrun), .lastSlot(lastSlot),
  .inReady(inReady), .inValid(inValid), .slotsM1(slotsM1)
);

// File: tb/tdm_fmt_tx_tb.sv
module tdm_fmt_tx_tb;
  localparam int DATA_W = 32;
  localparam int MAX_SLOTS = 16;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int SLOT_W = $clog2(MAX_SLOTS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [SLOT_W-1:0] cfgSlotsM1 = '0;
  logic [CNT_W-1:0] cfgSlotWidth = '0, cfgWordWidth = '0;
  logic [MAX_SLOTS-1:0] cfgSlotMask = '0;
  logic cfgSyncWord = 0, cfgSyncEarly = 0, cfgSyncLow = 0, cfgRightAlign = 0, cfgNetwork = 0;
  logic run = 1'b0;
  logic [DATA_W-1:0] inWord = '0;
  logic inValid = 1'b0;
  logic inReady, sdOut, fsOut, underrun, lastSlot, evenSlot;

  int checks = 0, fails = 0, takenCnt = 0, seedCnt = 0;
  bit srcOn = 1'b0;
  logic [31:0] srcQ[$];
  logic [31:0] wq[$];
  logic [4:0] expQ[$];
  string curTag = "R1";

  always #2 clk = ~clk;

  tdm_fmt_tx #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // word source
  always @(negedge clk) begin
    inValid <= srcOn && (srcQ.size() > 0);
    inWord  <= (srcQ.size() > 0) ? srcQ[0] : 32'h0;
  end
  always @(posedge clk) begin
    if (inReady && inValid) begin
      takenCnt++;
      if (srcQ.size() > 0) void'(srcQ.pop_front());
    end
  end

  // monitor: entry = {sd, fs, even, last, underrun}
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [4:0] e, g;
      e = expQ.pop_front();
      g = {sdOut, fsOut, evenSlot, lastSlot, underrun};
      chk(g == e, curTag, 32'(g), 32'(e));
    end
  end

  task automatic scen(input string tag, input bit doWrite, input int slots, input int sw,
                      input int ww, input logic [MAX_SLOTS-1:0] mask, input bit sWord,
                      input bit early, input bit low, input bit right, input bit net,
                      input int frames, input bit supply, input bit midWrite);
    int nWords;
    int total;
    curTag = tag;
    if (doWrite) begin
      @(negedge clk);
      cfgSlotsM1 = SLOT_W'(slots - 1); cfgSlotWidth = CNT_W'(sw); cfgWordWidth = CNT_W'(ww);
      cfgSlotMask = mask; cfgSyncWord = sWord; cfgSyncEarly = early; cfgSyncLow = low;
      cfgRightAlign = right; cfgNetwork = net; cfgWrite = 1'b1;
      @(negedge clk);
      cfgWrite = 1'b0;
    end
    takenCnt = 0;
    nWords = 0;
    wq.delete();
    for (int f = 0; f < frames; f++)
      for (int s = 0; s < slots; s++)
        if (mask[s] && (net || s == 0)) begin
          logic [31:0] w;
          seedCnt++;
          w = 32'h9E3779B9 * 32'(seedCnt) ^ 32'h5A5A0F0F;
          wq.push_back(w);
          if (supply) srcQ.push_back(w);
          nWords++;
        end
    srcOn = supply;
    @(negedge clk);
    run = 1'b1;
    @(posedge clk);
    // build expected stream
    total = 0;
    if (early) begin expQ.push_back({1'b0, 1'b1 ^ low, 3'b000}); total++; end
    for (int f = 0; f < frames; f++)
      for (int s = 0; s < slots; s++) begin
        bit act;
        logic [31:0] wv, sv;
        act = mask[s] && (net || s == 0);
        wv = 0;
        if (act) wv = wq.pop_front();
        if (!supply) wv = 0;
        wv = wv & ~(32'hFFFFFFFF << ww);
        sv = right ? wv : (wv << (sw - ww));
        for (int b = 0; b < sw; b++) begin
          bit fs;
          bit lastBitF;
          lastBitF = (s == slots - 1) && (b == sw - 1);
          case ({early, sWord})
            2'b00: fs = (s == 0) && (b == 0);
            2'b01: fs = (s == 0);
            2'b10: fs = lastBitF;
            default: fs = lastBitF || ((s == 0) && (b < sw - 1));
          endcase
          expQ.push_back({sv[sw-1-b], fs ^ low, (s % 2) == 0,
                          (s == slots - 1) && (b == 0), act && !supply && (b == 0)});
          total++;
        end
      end
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (midWrite && k == 10) begin
        cfgSlotsM1 = '0; cfgSlotWidth = CNT_W'(8); cfgSyncLow = ~low; cfgWrite = 1'b1;
      end
      if (midWrite && k == 11) cfgWrite = 1'b0;
    end
    run = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdOut == 1'b0, {tag, " R11 idle data"}, 32'(sdOut), 0);
    chk(fsOut == low, {tag, " R8 idle sync"}, 32'(fsOut), 32'(low));
    chk(takenCnt == (supply ? nWords : 0), {tag, " R4 R5 words taken"}, 32'(takenCnt),
        32'(supply ? nWords : 0));
    srcOn = 1'b0;
    srcQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({sdOut, fsOut, inReady, underrun, lastSlot, evenSlot} == 6'b0, "R1 reset outputs",
        32'({sdOut, fsOut, inReady, underrun, lastSlot, evenSlot}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({sdOut, fsOut, inReady, underrun, lastSlot, evenSlot} == 6'b0, "R1 idle outputs",
        32'({sdOut, fsOut, inReady, underrun, lastSlot, evenSlot}), 0);
    // defaults without any configuration write
    scen("R1 R2 default", 0, 2, 32, 32, 16'h0003, 1, 0, 0, 0, 1, 2, 1, 0);
    scen("R2 R6 left pad", 1, 4, 24, 16, 16'h000F, 1, 0, 0, 0, 1, 2, 1, 0);
    scen("R3 R6 right bitsync", 1, 2, 32, 20, 16'h0003, 0, 0, 0, 1, 1, 2, 1, 0);
    scen("R7 R8 i2s", 1, 2, 32, 24, 16'h0003, 1, 1, 1, 0, 1, 2, 1, 0);
    scen("R7 dsp early bit", 1, 4, 16, 16, 16'h000F, 0, 1, 0, 0, 1, 2, 1, 0);
    scen("R4 R10 mask", 1, 8, 8, 8, 16'h00B2, 0, 0, 0, 0, 1, 2, 1, 0);
    scen("R5 normal mode", 1, 4, 12, 12, 16'h000F, 1, 0, 0, 0, 0, 2, 1, 0);
    scen("R9 underrun", 1, 3, 16, 8, 16'h0007, 1, 0, 0, 0, 1, 2, 0, 0);
    scen("R12 R11 write while running", 1, 2, 16, 16, 16'h0003, 1, 0, 0, 0, 1, 3, 1, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R11: run did not finish, got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule